// File: doc/BRIEF.md
# External IRQ Sense and Request Register

This block samples eight external interrupt pins and keeps one request bit per pin in a 32-bit status word. A CPU reads and writes this word over a simple register bus that uses single-cycle read and write strobes. Each pin has its own 2-bit sense code. The code chooses edge detection (falling or rising) or level detection (active-low or active-high). Every pin passes through a two-stage synchronizer before any detection takes place.

An edge request stays latched until software clears it. To clear it, software must first read the bit as 1 and then write 0 to it. A level request has no stored state that software can reach, and writes to it do nothing. A global flag chooses what a level bit shows. With the flag at 0, the bit shows the raw asserted level. With the flag at 1, the bit shows the asserted level only until the CPU accepts that request. The CPU marks a request as accepted with a pulse that carries a 3-bit pin index. The combined request output is the OR of the eight bits.

Top module: `irq_sense_latch`

## Requirements
- R1: Pin n (n = 0..7) appears at status bit 31-n, so pin 0 is bit 31 and pin 7 is bit 24. Bits 23..0 always read 0, and writes to them change nothing.
- R2: After reset, the status word reads 0 and `req_o` is 0.
- R3: Sense code 2'b00 latches a falling edge, and 2'b01 latches a rising edge. The latched bit reads 1 from the third rising clock edge after the pin changes, and reads 0 before that edge.
- R4: Writing 1 to a latched edge bit leaves it at 1.
- R5: Writing 0 clears a latched edge bit only if a read since the previous write returned that bit as 1. A write consumes this permission, and a write of 0 without the permission leaves the bit at 1.
- R6: If a new detected edge and a clearing write fall in the same cycle, the bit stays at 1.
- R7: Sense code 2'b10 is active-low level and 2'b11 is active-high level. Writes have no effect on a level bit.
- R8: With `lvl_mode_i`=0, a level bit reads 1 exactly while the synchronized pin is asserted. It reads 1 from the second rising clock edge after the pin asserts.
- R9: With `lvl_mode_i`=1, a level bit reads 1 while the pin is asserted and not yet accepted. A pulse on `ack_i` with `ack_idx_i`=n marks pin n as accepted, which sets its bit to 0 from the next edge. A pulse with another index leaves pin n unaffected. The accepted state clears when the pin deasserts.
- R10: `req_o` is 1 exactly when any of the eight status bits is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 8 | Raw external interrupt pins, bit n is pin n |
| sense_i | input | 16 | Sense code of pin n at bits 2n+1..2n |
| lvl_mode_i | input | 1 | Level-bit view: 0 shows the raw level, 1 hides accepted requests |
| rd_i | input | 1 | Single-cycle status read strobe |
| wr_i | input | 1 | Single-cycle status write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Status word |
| ack_i | input | 1 | CPU acceptance pulse |
| ack_idx_i | input | 3 | Index of the pin being accepted |
| req_o | output | 1 | OR of all request bits |

## Verification
Three pieces of internal state can go wrong, and each shows up at the ports within a few cycles. A wrong latch bit is visible on `rdata_o` and `req_o` as soon as the next edge has passed. A lost or stuck read permission shows up on the first write of 0 that follows: the bit either survives when it should clear, or clears when it should survive. A wrong accepted state shows up one edge after the acceptance pulse, and again when the pin is toggled off and back on. Off-by-one errors in the synchronizer are caught by sampling the bit one edge before and at the edge where it is required to appear.

// File: rtl/irq_sense_latch.sv
module irq_sense_latch #(
  parameter int NIRQ = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NIRQ-1:0]         irq_pin_i,
  input  logic [2*NIRQ-1:0]       sense_i,
  input  logic                    lvl_mode_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  input  logic                    ack_i,
  input  logic [$clog2(NIRQ)-1:0] ack_idx_i,
  output logic                    req_o
);
  localparam int TOP = DW - 1;
  localparam int IW  = $clog2(NIRQ);
  localparam int LOW = DW - NIRQ;

  logic [NIRQ-1:0] s1, s2, s3;
  logic [NIRQ-1:0] lat, arm, acc;
  logic [NIRQ-1:0] edge_sel, asrt, hit, wbit, view;

  logic unused_wlow;
  assign unused_wlow = ^wdata_i[LOW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= irq_pin_i; s2 <= s1; s3 <= s2;
    end

  assign rdata_o[LOW-1:0] = '0;

  for (genvar n = 0; n < NIRQ; n++) begin : g_irq
    assign edge_sel[n] = ~sense_i[2*n+1];
    assign asrt[n]     = sense_i[2*n] ? s2[n] : ~s2[n];
    assign hit[n]      = edge_sel[n] & (sense_i[2*n] ? (s2[n] & ~s3[n]) : (~s2[n] & s3[n]));
    assign wbit[n]     = wdata_i[TOP-n];
    assign view[n]     = edge_sel[n] ? lat[n] : (asrt[n] & ~(lvl_mode_i & acc[n]));
    assign rdata_o[TOP-n] = view[n];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lat[n] <= 1'b0;
        arm[n] <= 1'b0;
        acc[n] <= 1'b0;
      end else begin
        if (!edge_sel[n])                    lat[n] <= 1'b0;
        else if (hit[n])                     lat[n] <= 1'b1;
        else if (wr_i && arm[n] && !wbit[n]) lat[n] <= 1'b0;

        if (wr_i)                arm[n] <= 1'b0;
        else if (rd_i && view[n]) arm[n] <= 1'b1;

        if (edge_sel[n] || !asrt[n])                 acc[n] <= 1'b0;
        else if (ack_i && ack_idx_i == IW'(n))       acc[n] <= 1'b1;
      end

    a_r4_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && edge_sel[n] && lat[n] && wbit[n]) |=> (lat[n] || !edge_sel[n]))
      else $error("R4 violated on irq %0d", n);

    a_r5_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !arm[n] && edge_sel[n] && lat[n]) |=> (lat[n] || !edge_sel[n]))
      else $error("R5 violated on irq %0d", n);

    a_r5_arm_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm[n]) |-> $past(rd_i && !wr_i))
      else $error("R5 arm without read on irq %0d", n);

    a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[n] && wr_i && !wbit[n]) |=> (lat[n] || !edge_sel[n]))
      else $error("R6 violated on irq %0d", n);

    a_r9_ack_hides: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_idx_i == IW'(n) && !edge_sel[n] && asrt[n] && lvl_mode_i)
        |=> (!view[n] || !lvl_mode_i || edge_sel[n]))
      else $error("R9 violated on irq %0d", n);
  end

  assign req_o = |view;

  a_r10_req_matches: assert property (@(posedge clk) disable iff (!rst_n)
    req_o == (rdata_o[TOP -: NIRQ] != '0))
    else $error("R10 violated");
endmodule

// File: tb/test_irq_sense_latch.sv
module test_irq_sense_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin = '0;
  logic [15:0] sense = {8{2'b01}};
  logic        lvl = 1'b0;
  logic        rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [31:0] wdata = '0;
  logic [2:0]  aidx = '0;
  logic [31:0] rdata;
  logic        req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  irq_sense_latch i_irq_sense_latch (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pin), .sense_i(sense),
    .lvl_mode_i(lvl), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .ack_i(ack), .ack_idx_i(aidx), .req_o(req));

  // {idx[2:0], sense[1:0], pin_before, pin_after, expected_bit}
  localparam logic [7:0] VEC [8] = '{
    8'b000_01_0_1_1, 8'b001_01_1_0_0, 8'b010_00_1_0_1, 8'b011_00_0_1_0,
    8'b100_11_0_1_1, 8'b101_11_1_0_0, 8'b110_10_1_0_1, 8'b111_10_0_1_0};

  function automatic logic [31:0] bitof(int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read();
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  task automatic do_write(logic [31:0] v);
    wr = 1'b1; wdata = v; step(1); wr = 1'b0; wdata = '0;
  endtask

  task automatic clear_all();
    do_read(); do_write(32'h0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R2 reset status", rdata, 32'h0);
    check("R2 reset req", {31'b0, req}, 32'h0);

    for (int v = 0; v < 8; v++) begin
      automatic int idx = int'(VEC[v][7:5]);
      sense[2*idx +: 2] = VEC[v][4:3];
      pin[idx] = VEC[v][2];
      step(5);
      clear_all();
      pin[idx] = VEC[v][1];
      step(5);
      check($sformatf("R1 R3 R7 R8 vector %0d status", v), rdata,
            VEC[v][0] ? bitof(idx) : 32'h0);
      check($sformatf("R10 vector %0d req", v), {31'b0, req}, {31'b0, VEC[v][0]});
      sense[2*idx +: 2] = 2'b01;
      step(1);
      pin[idx] = 1'b0;
      step(5);
      clear_all();
    end

    // R3 latency: rising edge on pin 1
    pin[1] = 1'b1;
    step(2);
    check("R3 not yet latched", rdata, 32'h0);
    step(1);
    check("R3 latched on third edge", rdata, bitof(1));
    // R1 reserved bits ignore writes
    do_write(32'h00FF_FFFF);
    check("R1 reserved write", rdata, bitof(1));
    // R4 write one keeps
    do_read(); do_write(32'hFFFF_FFFF);
    check("R4 write one keeps", rdata, bitof(1));
    // R5 write zero without fresh read keeps
    do_write(32'h0);
    check("R5 unarmed write zero keeps", rdata, bitof(1));
    do_read(); do_write(32'h0);
    check("R5 armed write zero clears", rdata, 32'h0);
    pin[1] = 1'b0;
    step(4);

    // R6 edge and clear in same cycle
    pin[0] = 1'b1; step(5); pin[0] = 1'b0; step(4);
    check("R6 setup latched", rdata, bitof(0));
    do_read();
    pin[0] = 1'b1;
    step(2);
    wr = 1'b1; wdata = 32'h0;
    step(1);
    wr = 1'b0;
    check("R6 edge wins over clear", rdata, bitof(0));
    do_read(); do_write(32'h0);
    check("R6 later clear works", rdata, 32'h0);
    pin[0] = 1'b0; step(4);

    // R8 level latency on pin 5, active high
    sense[11:10] = 2'b11;
    pin[5] = 1'b1;
    step(1);
    check("R8 not yet visible", rdata, 32'h0);
    step(1);
    check("R8 visible on second edge", rdata, bitof(5));
    // R7 writes no effect on level bit
    do_read(); do_write(32'h0);
    check("R7 level write zero", rdata, bitof(5));
    // R10 OR with a latched edge bit
    pin[2] = 1'b1; step(4);
    check("R10 two bits", rdata, bitof(5) | bitof(2));
    check("R10 req high", {31'b0, req}, 32'h1);

    // R9 acceptance
    lvl = 1'b1;
    step(1);
    check("R9 unaccepted visible", rdata, bitof(5) | bitof(2));
    ack = 1'b1; aidx = 3'd4; step(1); ack = 1'b0;
    check("R9 other index no effect", rdata, bitof(5) | bitof(2));
    ack = 1'b1; aidx = 3'd5; step(1); ack = 1'b0;
    check("R9 accepted hidden", rdata, bitof(2));
    lvl = 1'b0; step(1);
    check("R8 source view ignores acceptance", rdata, bitof(5) | bitof(2));
    lvl = 1'b1;
    do_read(); do_write(32'h0);
    check("R9 only level hidden left", rdata, 32'h0);
    check("R10 req low", {31'b0, req}, 32'h0);
    pin[5] = 1'b0; step(4);
    pin[5] = 1'b1; step(4);
    check("R9 acceptance cleared by deassert", rdata, bitof(5));

    // R7 active low on pin 6
    sense[13:12] = 2'b10;
    pin[6] = 1'b1; step(4);
    check("R7 active low idle", rdata & bitof(6), 32'h0);
    pin[6] = 1'b0; step(4);
    check("R7 active low asserted", rdata & bitof(6), bitof(6));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule